// File: doc/BRIEF.md
# Decoded Macroblock Output Sequencer

This block takes reconstructed macroblocks from the decode buffer and sends them to a display processor on a framed pixel bus. Input words are 32 bits wide and hold four adjacent pixels. They arrive through a valid/ready handshake. Each macroblock is 96 words. The side information for a macroblock is sampled with its last word: the field-IDCT flag, the frame-prediction flag, the end-of-row marker, the end-of-picture marker, the picture structure and the first-field indication.

Two macroblock banks are filled in turn. A bank is streamed only once all 96 of its words are held, so an output window never stalls partway through. The output side drives the pixel bus and three nested windows: macroblock, slice (one macroblock row) and picture. It also drives picture-structure and first-field outputs, and per-macroblock field-IDCT and frame-prediction flags. A wait input from the display side holds back the next macroblock. Luma words are reordered into field order when a frame picture's macroblock asks for it.

Top module: `mb_out_seq`

## Requirements
- R1: Every accepted word of a macroblock appears exactly once on `pix_o`, one word per clock, while `mb_win_o` is high. Macroblocks leave in the order they arrived. Side inputs are sampled with the 96th word of each macroblock.
- R2: `mb_win_o` stays high for exactly 96 consecutive clocks per macroblock and is never paused.
- R3: `mb_win_o` is low for at least 2 clocks between any two macroblock windows.
- R4: `slice_win_o` rises with the first macroblock window of a row. It stays high across the gaps inside that row. It falls on the same edge as the window of a macroblock flagged end-of-row or end-of-picture.
- R5: `pic_win_o` rises with the first macroblock window of a picture and falls on the same edge as the window of the macroblock flagged end-of-picture. Both `pic_win_o` and `slice_win_o` are high whenever `mb_win_o` is high.
- R6: `pic_struct_o` carries 1 for a top field, 2 for a bottom field and 3 for a frame picture. `top_first_no` is active low: it is 0 when the top field comes first. Both are loaded when a picture window opens and are held until the next one opens.
- R7: `field_idct_o` equals the macroblock's field-IDCT flag when the picture is a frame picture (structure 3). It is 0 otherwise.
- R8: A macroblock window never opens within 50 clocks after `wait_i` was sampled high. A window that has already opened completes regardless of `wait_i`.
- R9: `frame_pred_o` equals the macroblock's frame-prediction flag for frame pictures and is 0 for field pictures.
- R10: Word k of a macroblock as accepted sits at buffer position k. Positions 0..63 are luma, in 16 rows of 4 words. Positions 64..95 are chroma. In frame order, output word p is position p. In field order, the luma output takes rows 0,2,…,14 and then rows 1,3,…,15, each row in column order. Chroma is unchanged.
- R11: A macroblock window opens only after all 96 words of that macroblock have been accepted. `in_ready_o` drops only while both banks are full.
- R12: While reset is asserted, all outputs are 0 except `top_first_no`, which is 1, and `in_ready_o`, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input word accepted when high with valid |
| in_data_i | input | 32 | Four adjacent pixels |
| in_field_idct_i | input | 1 | Macroblock uses field-IDCT order (sampled with last word) |
| in_frame_pred_i | input | 1 | Macroblock frame prediction / frame DCT flag |
| in_row_end_i | input | 1 | Last macroblock of its row |
| in_pic_end_i | input | 1 | Last macroblock of its picture |
| in_pic_struct_i | input | 2 | Picture structure: 1 top, 2 bottom, 3 frame |
| in_top_first_i | input | 1 | Top field is output first |
| wait_i | input | 1 | Display side asks output to hold |
| pix_o | output | 32 | Output pixel word |
| mb_win_o | output | 1 | Macroblock window |
| slice_win_o | output | 1 | Slice (macroblock row) window |
| pic_win_o | output | 1 | Picture window |
| pic_struct_o | output | 2 | Structure of the picture being output |
| top_first_no | output | 1 | First-field parity, active low |
| field_idct_o | output | 1 | Current macroblock is in field-IDCT order |
| frame_pred_o | output | 1 | Current macroblock frame-prediction flag |

## Verification
The bench targets field-IDCT flags set inside field pictures. A design that failed to gate them would reorder words or raise `field_idct_o`/`frame_pred_o` where both must stay at frame order and 0. Wait pulses arrive just before and during macroblock windows. A design that checked the hold-off too early would open a window inside the 50-clock limit, and one that stalled mid-window would stretch it past 96 clocks. Rows of one to three macroblocks, and pictures that end in the middle of the input stream, expose a slice or picture window that drops too early, stays high too long, or latches the next picture's structure before its window opens. Slow and bursty input shows whether a window ever opens before its whole macroblock has arrived.

// File: rtl/mb_out_pkg.sv
package mb_out_pkg;

  typedef enum logic [1:0] {
    PS_NONE  = 2'd0,
    PS_TOP   = 2'd1,
    PS_BOT   = 2'd2,
    PS_FRAME = 2'd3
  } pic_struct_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_GAP
  } seq_state_e;

  typedef struct packed {
    logic       field_idct;
    logic       frame_pred;
    logic       row_end;
    logic       pic_end;
    logic [1:0] pic_struct;
    logic       top_first;
  } mb_side_t;

endpackage

// File: rtl/mb_bank_buf.sv
module mb_bank_buf
  import mb_out_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned MB_WORDS  = 96,
  parameter int unsigned NUM_BANKS = 2,
  localparam int unsigned IDX_W    = $clog2(MB_WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_data_i,
  input  mb_side_t          in_side_i,
  input  logic [IDX_W-1:0]  rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output mb_side_t          rd_side_o,
  output logic              rd_full_o,
  input  logic              release_i
);

  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int unsigned DEPTH  = NUM_BANKS * MB_WORDS;
  localparam int unsigned ADDR_W = $clog2(DEPTH);

  logic [WORD_W-1:0]    mem_q [DEPTH];
  mb_side_t             side_q [NUM_BANKS];
  logic [NUM_BANKS-1:0] full_q;
  logic [BANK_W-1:0]    wr_ptr_q, rd_ptr_q;
  logic [IDX_W-1:0]     wr_idx_q;
  logic                 push, push_last;
  logic [ADDR_W-1:0]    wr_addr, rd_addr;

  function automatic logic [BANK_W-1:0] bump(input logic [BANK_W-1:0] p);
    return (p == BANK_W'(NUM_BANKS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign in_ready_o = !full_q[wr_ptr_q];
  assign push       = in_valid_i && in_ready_o;
  assign push_last  = push && (wr_idx_q == IDX_W'(MB_WORDS - 1));

  assign wr_addr = ADDR_W'(wr_ptr_q) * ADDR_W'(MB_WORDS) + ADDR_W'(wr_idx_q);
  assign rd_addr = ADDR_W'(rd_ptr_q) * ADDR_W'(MB_WORDS) + ADDR_W'(rd_addr_i);

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wr_addr] <= in_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      wr_idx_q <= '0;
    end else begin
      if (push) wr_idx_q <= push_last ? '0 : wr_idx_q + 1'b1;
      if (push_last) wr_ptr_q <= bump(wr_ptr_q);
      if (release_i) rd_ptr_q <= bump(rd_ptr_q);
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        full_q[b] <= 1'b0;
        side_q[b] <= '0;
      end else begin
        if (push_last && wr_ptr_q == BANK_W'(b)) begin
          full_q[b] <= 1'b1;
          side_q[b] <= in_side_i;
        end else if (release_i && rd_ptr_q == BANK_W'(b)) begin
          full_q[b] <= 1'b0;
        end
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr];
  assign rd_side_o = side_q[rd_ptr_q];
  assign rd_full_o = full_q[rd_ptr_q];

  // R11
  release_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |-> full_q[rd_ptr_q]);

  // R11
  ready_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> (full_q[wr_ptr_q] && rd_ptr_q == wr_ptr_q));

endmodule

// File: rtl/mb_wait_gate.sv
module mb_wait_gate #(
  parameter int unsigned WAIT_HOLD = 50,
  localparam int unsigned CNT_W    = $clog2(WAIT_HOLD + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_i,
  output logic clear_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (wait_i)         cnt_q <= CNT_W'(WAIT_HOLD);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign clear_o = !wait_i && (cnt_q == '0);

endmodule

// File: rtl/mb_word_order.sv
module mb_word_order #(
  parameter int unsigned MB_WORDS  = 96,
  parameter int unsigned LUMA_ROWS = 16,
  parameter int unsigned ROW_WORDS = 4,
  localparam int unsigned IDX_W    = $clog2(MB_WORDS + 1)
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic             field_i,
  output logic [IDX_W-1:0] addr_o
);

  localparam int unsigned LUMA_WORDS = LUMA_ROWS * ROW_WORDS;
  localparam int unsigned HALF_ROWS  = LUMA_ROWS / 2;

  function automatic logic [IDX_W-1:0] field_map(input logic [IDX_W-1:0] p);
    int unsigned i, row, col, src;
    i   = 32'(p);
    row = i / ROW_WORDS;
    col = i % ROW_WORDS;
    src = (row < HALF_ROWS) ? 2 * row : 2 * (row - HALF_ROWS) + 1;
    return IDX_W'(src * ROW_WORDS + col);
  endfunction

  if (LUMA_ROWS % 2 == 0) begin : g_field
    always_comb begin
      if (32'(idx_i) >= MB_WORDS)                      addr_o = '0;
      else if (field_i && 32'(idx_i) < LUMA_WORDS)     addr_o = field_map(idx_i);
      else                                             addr_o = idx_i;
    end
  end else begin : g_frame_only
    assign addr_o = (32'(idx_i) >= MB_WORDS) ? '0 : idx_i;
  end

endmodule

// File: rtl/mb_out_seq.sv
module mb_out_seq
  import mb_out_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned MB_WORDS  = 96,
  parameter int unsigned LUMA_ROWS = 16,
  parameter int unsigned ROW_WORDS = 4,
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned WAIT_HOLD = 50,
  parameter int unsigned GAP_CLKS  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_data_i,
  input  logic              in_field_idct_i,
  input  logic              in_frame_pred_i,
  input  logic              in_row_end_i,
  input  logic              in_pic_end_i,
  input  logic [1:0]        in_pic_struct_i,
  input  logic              in_top_first_i,
  input  logic              wait_i,
  output logic [WORD_W-1:0] pix_o,
  output logic              mb_win_o,
  output logic              slice_win_o,
  output logic              pic_win_o,
  output logic [1:0]        pic_struct_o,
  output logic              top_first_no,
  output logic              field_idct_o,
  output logic              frame_pred_o
);

  localparam int unsigned IDX_W = $clog2(MB_WORDS + 1);
  localparam int unsigned GAP_W = $clog2(GAP_CLKS + 1);

  mb_side_t          in_side, rd_side;
  logic              rd_full, gate_clear, rel;
  logic [WORD_W-1:0] rd_data;
  logic [IDX_W-1:0]  idx_q, rd_addr;
  seq_state_e        state_q;
  logic [GAP_W-1:0]  gap_q;
  logic              row_end_q, pic_end_q;
  logic              last_word, slot_open, start, frame_pic;
  logic [1:0]        next_ps;

  always_comb begin
    in_side            = '0;
    in_side.field_idct = in_field_idct_i;
    in_side.frame_pred = in_frame_pred_i;
    in_side.row_end    = in_row_end_i;
    in_side.pic_end    = in_pic_end_i;
    in_side.pic_struct = in_pic_struct_i;
    in_side.top_first  = in_top_first_i;
  end

  mb_bank_buf #(
    .WORD_W   (WORD_W),
    .MB_WORDS (MB_WORDS),
    .NUM_BANKS(NUM_BANKS)
  ) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o),
    .in_data_i (in_data_i),
    .in_side_i (in_side),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .rd_side_o (rd_side),
    .rd_full_o (rd_full),
    .release_i (rel)
  );

  mb_wait_gate #(.WAIT_HOLD(WAIT_HOLD)) u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wait_i (wait_i),
    .clear_o(gate_clear)
  );

  mb_word_order #(
    .MB_WORDS (MB_WORDS),
    .LUMA_ROWS(LUMA_ROWS),
    .ROW_WORDS(ROW_WORDS)
  ) u_ord (
    .idx_i  (idx_q),
    .field_i(field_idct_o),
    .addr_o (rd_addr)
  );

  assign last_word = (state_q == ST_RUN) && (idx_q == IDX_W'(MB_WORDS));
  assign slot_open = (state_q == ST_IDLE) || (state_q == ST_GAP && gap_q == '0);
  assign start     = slot_open && rd_full && gate_clear;
  assign rel       = last_word;
  // picture-level structure is frozen once the picture window is open
  assign next_ps   = pic_win_o ? pic_struct_o : rd_side.pic_struct;
  assign frame_pic = (next_ps == PS_FRAME);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      idx_q        <= '0;
      gap_q        <= '0;
      row_end_q    <= 1'b0;
      pic_end_q    <= 1'b0;
      pix_o        <= '0;
      mb_win_o     <= 1'b0;
      slice_win_o  <= 1'b0;
      pic_win_o    <= 1'b0;
      pic_struct_o <= PS_NONE;
      top_first_no <= 1'b1;
      field_idct_o <= 1'b0;
      frame_pred_o <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_GAP: begin
          if (state_q == ST_GAP && gap_q != '0) gap_q <= gap_q - 1'b1;
          if (start) begin
            state_q      <= ST_RUN;
            mb_win_o     <= 1'b1;
            slice_win_o  <= 1'b1;
            pic_win_o    <= 1'b1;
            pix_o        <= rd_data;
            idx_q        <= IDX_W'(1);
            field_idct_o <= rd_side.field_idct && frame_pic;
            frame_pred_o <= rd_side.frame_pred && frame_pic;
            row_end_q    <= rd_side.row_end || rd_side.pic_end;
            pic_end_q    <= rd_side.pic_end;
            if (!pic_win_o) begin
              pic_struct_o <= rd_side.pic_struct;
              top_first_no <= !rd_side.top_first;
            end
          end else if (state_q == ST_GAP && gap_q == '0) begin
            state_q <= ST_IDLE;
          end
        end
        ST_RUN: begin
          if (last_word) begin
            state_q  <= ST_GAP;
            mb_win_o <= 1'b0;
            idx_q    <= '0;
            gap_q    <= GAP_W'(GAP_CLKS - 1);
            if (row_end_q) slice_win_o <= 1'b0;
            if (pic_end_q) pic_win_o   <= 1'b0;
          end else begin
            pix_o <= rd_data;
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // ---- checks ----
  localparam int unsigned SW = $clog2(WAIT_HOLD + 2);
  logic [IDX_W-1:0] run_q;
  logic [GAP_W-1:0] low_q;
  logic [SW-1:0]    since_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= '0;
      low_q   <= '0;
      since_q <= SW'(WAIT_HOLD + 1);
      seen_q  <= 1'b0;
    end else begin
      run_q <= mb_win_o ? run_q + 1'b1 : '0;
      if (mb_win_o)                         low_q <= '0;
      else if (low_q != GAP_W'(GAP_CLKS))   low_q <= low_q + 1'b1;
      if (wait_i)                                 since_q <= '0;
      else if (since_q != SW'(WAIT_HOLD + 1))     since_q <= since_q + 1'b1;
      if (mb_win_o) seen_q <= 1'b1;
    end
  end

  // R2
  win_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mb_win_o) |-> run_q == IDX_W'(MB_WORDS));

  // R3
  win_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mb_win_o) && seen_q) |-> low_q >= GAP_W'(GAP_CLKS));

  // R8
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mb_win_o) |-> since_q >= SW'(WAIT_HOLD));

  // R5
  win_nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mb_win_o |-> (slice_win_o && pic_win_o));

  // R7
  fidct_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_idct_o |-> pic_struct_o == PS_FRAME);

  // R9
  fpred_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_pred_o |-> pic_struct_o == PS_FRAME);

  // R6
  ps_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pic_win_o && $past(pic_win_o)) |-> $stable(pic_struct_o));

  // R11
  start_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mb_win_o) |-> $past(rd_full));

endmodule

// File: tb/tb_mb_out_seq.sv
module tb_mb_out_seq;

  localparam int N_MB = 24;
  localparam int MBW  = 96;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [31:0] in_data = '0;
  logic        in_fid = 1'b0, in_fpr = 1'b0, in_eor = 1'b0, in_eop = 1'b0, in_top = 1'b0;
  logic [1:0]  in_ps = '0;
  logic        wait_in = 1'b0;
  logic [31:0] pix;
  logic        mb_win, slice_win, pic_win, top_first_n, field_idct, frame_pred;
  logic [1:0]  pic_struct;

  always #4 clk = ~clk;

  mb_out_seq dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_field_idct_i(in_fid), .in_frame_pred_i(in_fpr), .in_row_end_i(in_eor),
    .in_pic_end_i(in_eop), .in_pic_struct_i(in_ps), .in_top_first_i(in_top),
    .wait_i(wait_in), .pix_o(pix), .mb_win_o(mb_win), .slice_win_o(slice_win),
    .pic_win_o(pic_win), .pic_struct_o(pic_struct), .top_first_no(top_first_n),
    .field_idct_o(field_idct), .frame_pred_o(frame_pred)
  );

  int total = 0, bad = 0;
  bit fid[N_MB], fpr[N_MB], eor[N_MB], eop[N_MB], top[N_MB];
  bit [1:0] ps[N_MB];
  int acc = 0, mk = 0, pos = 0, low = 0, since = 1000, cyc = 0;
  bit prev_win = 0, fo = 0, feeding_done = 0;

  function automatic logic [31:0] word_of(int k, int i);
    return {8'(k) ^ 8'hA5, 8'(i), 16'(k * 733 + i * 97)};
  endfunction

  function automatic int src_of(int p, bit field);
    int row, srow;
    if (!field || p >= 64) return p;
    row  = p / 4;
    srow = (row < 8) ? 2 * row : 2 * (row - 8) + 1;
    return srow * 4 + (p % 4);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h (mb %0d pos %0d)", req, act, exp, mk, pos);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // build the macroblock plan
  initial begin
    int k, pic, rows, cols;
    bit [1:0] p_ps;
    bit p_top;
    void'($urandom(32'h1bad));
    k = 0; pic = 0;
    while (k < N_MB) begin
      p_ps  = (pic == 0) ? 2'd3 : (pic == 1) ? 2'd1 : 2'(1 + $urandom % 3);
      p_top = 1'($urandom % 2);
      rows  = 1 + $urandom % 2;
      cols  = 1 + $urandom % 3;
      for (int r = 0; r < rows; r++)
        for (int c = 0; c < cols; c++)
          if (k < N_MB) begin
            ps[k]  = p_ps;
            top[k] = p_top;
            fid[k] = 1'($urandom % 2);
            fpr[k] = 1'($urandom % 2);
            eor[k] = (c == cols - 1) || (k == N_MB - 1);
            eop[k] = (r == rows - 1 && c == cols - 1) || (k == N_MB - 1);
            if (c == 0 && r == 0 && pic < 2) begin fid[k] = 1; fpr[k] = 1; end
            k++;
          end
      pic++;
    end
  end

  always @(posedge clk) begin
    since <= wait_in ? 0 : since + 1;
    cyc   <= cyc + 1;
    if (cyc > 150000) begin
      chk(0, "watchdog", 32'(mk), 32'(N_MB));
      summary();
    end
  end

  // reset state, then feeder
  initial begin
    repeat (3) @(negedge clk);
    // R12
    chk(pix == 0, "R12 pix", pix, 0);
    chk(mb_win == 0 && slice_win == 0 && pic_win == 0, "R12 windows",
        {mb_win, slice_win, pic_win}, 0);
    chk(pic_struct == 0 && field_idct == 0 && frame_pred == 0, "R12 flags",
        {pic_struct, field_idct, frame_pred}, 0);
    chk(top_first_n == 1, "R12 top_first_no", top_first_n, 1);
    chk(in_ready == 1, "R12 ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < N_MB; k++) begin
      for (int i = 0; i < MBW; i++) begin
        if ($urandom % 8 == 0) begin in_valid = 0; @(negedge clk); end
        in_valid = 1;
        in_data  = word_of(k, i);
        in_fid = fid[k]; in_fpr = fpr[k]; in_eor = eor[k]; in_eop = eop[k];
        in_ps  = ps[k];  in_top = top[k];
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        acc++;
        @(negedge clk);
      end
      in_valid = 0;
      // slow producer for a few macroblocks
      if (k > 15 && k < 19) repeat (150) @(negedge clk);
    end
    in_valid = 0;
    feeding_done = 1;
  end

  // wait stimulus: directed hold at start and mid-stream, random pulses
  initial begin
    @(posedge rst_n);
    @(negedge clk);
    wait_in = 1; repeat (3) @(negedge clk); wait_in = 0;
    while (mk < N_MB) begin
      @(negedge clk);
      if (cyc == 1500) begin
        wait_in = 1; repeat (20) @(negedge clk); wait_in = 0;
      end else if ($urandom % 70 == 0) begin
        wait_in = 1; repeat (1 + $urandom % 4) @(negedge clk); wait_in = 0;
      end
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (rst_n && mk < N_MB) begin
      if (mb_win) begin
        if (!prev_win) begin
          fo  = fid[mk] && ps[mk] == 2'd3;
          pos = 0;
          // R3
          if (mk > 0) chk(low >= 2, "R3 gap", 32'(low), 2);
          // R8
          chk(since >= 50, "R8 wait holdoff", 32'(since), 50);
          // R11
          chk(acc >= (mk + 1) * MBW, "R11 full before open", 32'(acc), 32'((mk + 1) * MBW));
          // R4 R5
          chk(slice_win && pic_win, "R4/R5 windows open", {slice_win, pic_win}, 2'b11);
          // R6
          chk(pic_struct == ps[mk], "R6 pic_struct", pic_struct, ps[mk]);
          chk(top_first_n == !top[mk], "R6 top_first_no", top_first_n, !top[mk]);
          // R7
          chk(field_idct == fo, "R7 field_idct", field_idct, fo);
          // R9
          chk(frame_pred == (fpr[mk] && ps[mk] == 2'd3), "R9 frame_pred", frame_pred,
              fpr[mk] && ps[mk] == 2'd3);
        end
        // R1 R10
        if (pos < MBW)
          chk(pix == word_of(mk, src_of(pos, fo)), "R1/R10 word", pix,
              word_of(mk, src_of(pos, fo)));
        pos++;
        low = 0;
      end else if (prev_win) begin
        // R2
        chk(pos == MBW, "R2 window length", 32'(pos), MBW);
        // R4
        chk(slice_win == !eor[mk], "R4 slice close", slice_win, !eor[mk]);
        // R5
        chk(pic_win == !eop[mk], "R5 pic close", pic_win, !eop[mk]);
        mk++;
        low = 1;
      end else begin
        low++;
      end
      prev_win = mb_win;
    end
  end

  initial begin
    wait (mk == N_MB && feeding_done);
    repeat (5) @(negedge clk);
    chk(!mb_win && !slice_win && !pic_win, "R5 idle after last", {mb_win, slice_win, pic_win}, 0);
    chk(in_ready == 1, "R11 ready when drained", in_ready, 1);
    summary();
  end

endmodule